// File: doc/BRIEF.md
# Bit-Banged Serial EEPROM Slave

This block models a small three-wire serial EEPROM that software drives one bit at a time through a single control byte. Every bus write to that byte sets new levels on the chip-select, serial-clock and data-in lines. The block finds line edges by comparing each written byte with the byte stored from the previous write. A chip-select rising edge opens a command. The host then sends a start bit, a 2-bit opcode and an 8-bit word address, most significant bit first, followed by 16 data bits if the opcode needs them.

The block holds 256 words of 16 bits. Each word stands for a big-endian byte pair, with the high byte at the even byte address. A 17-bit shift register gathers incoming bits and also supplies the serial output. Bus reads of the control byte return bit 16 of that register. Write-type commands are not stored until chip-select rises again. Writing is gated by an enable flag that software sets and clears with commands.

Top module: `bitbang_eeprom`

## Requirements
- R1: Out of reset every word reads 0xFFFF, writing is disabled, and the status byte reads 0x01.
- R2: In the control byte, bit 7 is chip-select, bit 6 is the serial clock and bit 1 is data-in. An edge exists only when a written byte differs from the previous written byte in that bit, so writing the same byte twice gives no second edge. The status byte returns the output bit in bit 0 and zeros in bits 7:1.
- R3: A chip-select rising edge, outside the pending-store state, puts the block in idle. In idle, a clock rising edge with data-in 0 is ignored, and one with data-in 1 is the start bit.
- R4: Read uses opcode 2 (bits 1,0). After the 8 address bits and one further clock rising edge, the status bit shows word bits 15 down to 0, one new bit after each clock falling edge.
- R5: While writing is disabled, the write, erase, write-all and erase-all commands leave every word unchanged.
- R6: Opcode 0 with address bits [7:6] = 11 enables writing and with [7:6] = 00 disables it. Either takes effect at the last address bit, with no data bits.
- R7: Write uses opcode 1. The 16 data bits are sent MSB first and are stored to the addressed word on the next chip-select rising edge.
- R8: Erase uses opcode 3. After 16 clocked bits of any value, the next chip-select rising edge stores 0xFFFF to the addressed word.
- R9: Opcode 0 with address bits [7:6] = 01, followed by 16 data bits, sets every word to that data.
- R10: Opcode 0 with address bits [7:6] = 10, followed by 16 bits, sets every word to 0xFFFF. The received bits are then also stored to the captured address on the chip-select rising edge.
- R11: After a store on chip-select rise, the status bit reads 1. Clock edges are then ignored until chip-select rises again.
- R12: A chip-select rising edge before a command completes abandons the command and stores nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctlWrite | input | 1 | Bus write strobe for the control byte |
| ctlByte | input | 8 | Written control byte (chip-select, clock, data-in) |
| statusByte | output | 8 | Read value of the control byte; bit 0 is the serial output |

## Verification
The hardest case to reach is the interaction between the chip-select edge and the pending store. One case is a store that must happen only on the closing edge. The other is a half-sent command that the same edge must abandon. Both need a full serial frame built from dozens of byte writes. The bench therefore uses tasks that send each bit as a clock-low write followed by a clock-high write. It stops a write frame after 8 data bits to show the abandon case. It also repeats clock-high bytes, sends zero bits while idle, and clocks the lines while the block sits in the null state. Every result is read back through the serial read command at the status bit.

// File: rtl/bbee_pkg.sv
package bbee_pkg;
  typedef enum logic [3:0] {
    ST_NULL, ST_IDLE, ST_OPCODE, ST_ADDR, ST_SPECIAL,
    ST_WDATA, ST_RLATCH, ST_EDATA, ST_COMMIT, ST_READ
  } phase_t;

  typedef struct packed {
    logic shiftIn;
    logic shiftOut;
    logic clear;
    logic loadOnes;
    logic loadWord;
    logic loadErased;
    logic commit;
    logic fillData;
    logic fillErased;
  } strobe_t;
endpackage

// File: rtl/bbee_ctrl.sv
module bbee_ctrl
  import bbee_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int WORD_W  = 16,
  parameter int CS_POS  = 7,
  parameter int CLK_POS = 6,
  parameter int DIN_POS = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctlWrite,
  input  logic [7:0]        ctlByte,
  input  logic [ADDR_W-2:0] srTail,
  output strobe_t           stb,
  output logic [ADDR_W-1:0] wordAddr,
  output logic              dinBit
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam int OPC_W = 2;
  localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);
  localparam logic [CNT_W-1:0] OPC_LAST  = CNT_W'(OPC_W);
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(WORD_W);
  localparam logic [7:0] DIN_CLR = ~(8'(1) << DIN_POS);

  phase_t            state, stateNxt, eff;
  logic [CNT_W-1:0]  bits, bitsNxt, bitsInc;
  logic [OPC_W-1:0]  opcode, opcodeNxt;
  logic [ADDR_W-1:0] addrNxt, freshAddr;
  logic              wen, wenNxt;
  logic [7:0]        prevCtl;
  logic              csRise, clkRise, clkFall, shiftable;

  assign dinBit    = ctlByte[DIN_POS];
  assign csRise    = ctlWrite && !prevCtl[CS_POS] && ctlByte[CS_POS];
  assign clkRise   = ctlWrite && !prevCtl[CLK_POS] && ctlByte[CLK_POS];
  assign clkFall   = ctlWrite && prevCtl[CLK_POS] && !ctlByte[CLK_POS];
  assign bitsInc   = bits + ONE;
  assign freshAddr = {srTail, dinBit};

  always_comb begin
    stateNxt  = state;
    bitsNxt   = bits;
    opcodeNxt = opcode;
    addrNxt   = wordAddr;
    wenNxt    = wen;
    stb       = '0;
    eff       = state;
    if (csRise) begin
      if (state == ST_COMMIT) begin
        stb.commit   = wen;
        stb.loadOnes = 1'b1;
        eff          = ST_NULL;
      end else begin
        eff = ST_IDLE;
      end
      stateNxt = eff;
    end
    shiftable = !(eff inside {ST_NULL, ST_IDLE, ST_READ});
    if (clkRise) begin
      if (shiftable) begin
        stb.shiftIn = 1'b1;
        bitsNxt     = bitsInc;
      end
      case (eff)
        ST_IDLE: if (dinBit) begin
          stb.clear = 1'b1;
          bitsNxt   = '0;
          stateNxt  = ST_OPCODE;
        end
        ST_OPCODE: if (bitsInc == OPC_LAST) begin
          opcodeNxt = {srTail[0], dinBit};
          bitsNxt   = '0;
          stateNxt  = ST_ADDR;
        end
        ST_ADDR: if (bitsInc == ADDR_LAST) begin
          addrNxt = freshAddr;
          bitsNxt = '0;
          case (opcode)
            2'd0: begin
              case (freshAddr[ADDR_W-1 -: 2])
                2'b00:   begin wenNxt = 1'b0; stateNxt = ST_NULL; end
                2'b11:   begin wenNxt = 1'b1; stateNxt = ST_NULL; end
                default: stateNxt = ST_SPECIAL;
              endcase
            end
            2'd1:    stateNxt = ST_WDATA;
            2'd2:    stateNxt = ST_RLATCH;
            default: stateNxt = ST_EDATA;
          endcase
        end
        ST_SPECIAL: if (bitsInc == DATA_LAST) begin
          stateNxt = ST_COMMIT;
          if (wordAddr[ADDR_W-1 -: 2] == 2'b01) stb.fillData = wen;
          else                                  stb.fillErased = wen;
        end
        ST_WDATA: if (bitsInc == DATA_LAST) begin
          bitsNxt  = '0;
          stateNxt = ST_COMMIT;
        end
        ST_RLATCH: if (bitsInc == ONE) begin
          stb.loadWord = 1'b1;
          bitsNxt      = '0;
          stateNxt     = ST_READ;
        end
        ST_EDATA: if (bitsInc == DATA_LAST) begin
          stb.loadErased = 1'b1;
          bitsNxt        = '0;
          stateNxt       = ST_COMMIT;
        end
        default: ;
      endcase
    end else if (clkFall && eff == ST_READ) begin
      stb.shiftOut = 1'b1;
      bitsNxt      = bitsInc;
      if (bitsInc == DATA_LAST) begin
        bitsNxt  = '0;
        stateNxt = ST_NULL;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_NULL;
      bits     <= '0;
      opcode   <= '0;
      wordAddr <= '0;
      wen      <= 1'b0;
      prevCtl  <= '0;
    end else begin
      state    <= stateNxt;
      bits     <= bitsNxt;
      opcode   <= opcodeNxt;
      wordAddr <= addrNxt;
      wen      <= wenNxt;
      if (ctlWrite) prevCtl <= ctlByte & DIN_CLR;
    end
  end

  assert_quiet_without_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    !ctlWrite |=> $stable(state));
  assert_enable_changes_at_address_R6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(wen) |-> $past(state) == ST_ADDR);
  assert_store_returns_null_R11: assert property (@(posedge clk) disable iff (!rstN)
    (csRise && state == ST_COMMIT) |=> state == ST_NULL);
  assert_abandon_to_idle_R12: assert property (@(posedge clk) disable iff (!rstN)
    (csRise && state != ST_COMMIT && !clkRise) |=> state == ST_IDLE);
  assert_store_only_pending_R7: assert property (@(posedge clk) disable iff (!rstN)
    stb.commit |-> state == ST_COMMIT);
endmodule

// File: rtl/bbee_datapath.sv
module bbee_datapath
  import bbee_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic              dinBit,
  input  logic [ADDR_W-1:0] wordAddr,
  output logic [ADDR_W-2:0] srTail,
  output logic              statusBit
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int SR_W  = WORD_W + 1;
  localparam logic [WORD_W-1:0] ERASED = '1;

  logic [SR_W-1:0]   sr;
  logic [SR_W-1:0]   srShifted;
  logic [WORD_W-1:0] mem [DEPTH];

  assign srShifted = {sr[WORD_W-1:0], dinBit};
  assign srTail    = sr[ADDR_W-2:0];
  assign statusBit = sr[SR_W-1];

  always_ff @(posedge clk) begin
    if (!rstN)               sr <= '1;
    else if (stb.loadOnes)   sr <= '1;
    else if (stb.clear)      sr <= '0;
    else if (stb.loadWord)   sr <= {1'b0, mem[wordAddr]};
    else if (stb.loadErased) sr <= {1'b0, ERASED};
    else if (stb.shiftIn)    sr <= srShifted;
    else if (stb.shiftOut)   sr <= {sr[SR_W-2:0], 1'b0};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= ERASED;
    end else if (stb.fillErased) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= ERASED;
    end else if (stb.fillData) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= srShifted[WORD_W-1:0];
    end else if (stb.commit) begin
      mem[wordAddr] <= sr[WORD_W-1:0];
    end
  end

  assert_ready_after_store_R11: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadOnes |=> statusBit);
  assert_read_load_clears_top_R4: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadWord |=> !statusBit);
  assert_fill_not_with_store_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.commit && (stb.fillData || stb.fillErased)));
endmodule

// File: rtl/bitbang_eeprom.sv
module bitbang_eeprom
  import bbee_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int WORD_W  = 16,
  parameter int CS_POS  = 7,
  parameter int CLK_POS = 6,
  parameter int DIN_POS = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctlWrite,
  input  logic [7:0] ctlByte,
  output logic [7:0] statusByte
);
  strobe_t           stb;
  logic [ADDR_W-1:0] wordAddr;
  logic [ADDR_W-2:0] srTail;
  logic              dinBit;
  logic              statusBit;

  bbee_ctrl #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W),
    .CS_POS(CS_POS), .CLK_POS(CLK_POS), .DIN_POS(DIN_POS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .ctlWrite(ctlWrite), .ctlByte(ctlByte),
    .srTail(srTail), .stb(stb), .wordAddr(wordAddr), .dinBit(dinBit)
  );

  bbee_datapath #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .dinBit(dinBit),
    .wordAddr(wordAddr), .srTail(srTail), .statusBit(statusBit)
  );

  assign statusByte = {7'b0, statusBit};
endmodule

// File: tb/tb_bitbang_eeprom.sv
module tb_bitbang_eeprom;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ctlWrite = 1'b0;
  logic [7:0] ctlByte = '0;
  logic [7:0] statusByte;
  int nChecks = 0;
  int nFail = 0;
  logic finished = 1'b0;

  localparam logic [23:0] VEC [6] = '{
    {8'h00, 16'h0000}, {8'hFF, 16'hA55A}, {8'h30, 16'h8001},
    {8'h31, 16'h1234}, {8'h7E, 16'hFFFE}, {8'hC3, 16'h7F00}
  };

  bitbang_eeprom dut (
    .clk(clk), .rstN(rstN), .ctlWrite(ctlWrite),
    .ctlByte(ctlByte), .statusByte(statusByte)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic ctl(input logic cs, input logic sk, input logic di);
    @(negedge clk);
    ctlByte  = {cs, sk, 4'b0, di, 1'b0};
    ctlWrite = 1'b1;
    @(negedge clk);
    ctlWrite = 1'b0;
  endtask

  task automatic sendBit(input logic b);
    ctl(1'b1, 1'b0, b);
    ctl(1'b1, 1'b1, b);
  endtask

  task automatic sendField(input logic [15:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) sendBit(v[i]);
  endtask

  task automatic openCmd();
    ctl(1'b0, 1'b0, 1'b0);
    ctl(1'b1, 1'b0, 1'b0);
  endtask

  task automatic closeCmd();
    ctl(1'b0, 1'b0, 1'b0);
    ctl(1'b1, 1'b0, 1'b0);
    ctl(1'b0, 1'b0, 1'b0);
  endtask

  task automatic cmd(input logic [1:0] op, input logic [7:0] a, input logic [15:0] d, input logic withData);
    openCmd();
    sendBit(1'b1);
    sendField({14'b0, op}, 2);
    sendField({8'b0, a}, 8);
    if (withData) sendField(d, 16);
    closeCmd();
  endtask

  task automatic readWord(input logic [7:0] a, output logic [15:0] w);
    openCmd();
    sendBit(1'b1);
    sendField(16'd2, 2);
    sendField({8'b0, a}, 8);
    sendBit(1'b0);
    for (int i = 15; i >= 0; i--) begin
      ctl(1'b1, 1'b0, 1'b0);
      w[i] = statusByte[0];
      ctl(1'b1, 1'b1, 1'b0);
    end
    closeCmd();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    logic [15:0] w;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1, R2: reset status byte
    chk("R1 reset status", {24'b0, statusByte}, 32'h01);
    readWord(8'h00, w); chk("R1 reset word 00", {16'b0, w}, 32'hFFFF);
    readWord(8'hFF, w); chk("R1 reset word FF", {16'b0, w}, 32'hFFFF);

    // R5: write while disabled
    cmd(2'd1, 8'h10, 16'h1234, 1'b1);
    readWord(8'h10, w); chk("R5 disabled write", {16'b0, w}, 32'hFFFF);

    // R6: enable
    cmd(2'd0, 8'hC0, 16'h0, 1'b0);

    // R7, R4: table of write/read vectors
    for (int k = 0; k < 6; k++) begin
      cmd(2'd1, VEC[k][23:16], VEC[k][15:0], 1'b1);
      chk("R11 status after store", {24'b0, statusByte}, 32'h01);
      readWord(VEC[k][23:16], w);
      chk("R7 R4 write/read", {16'b0, w}, {16'b0, VEC[k][15:0]});
    end

    // R11: null state ignores clocks until chip-select rises
    cmd(2'd1, 8'h22, 16'h0F0F, 1'b1);
    for (int k = 0; k < 3; k++) begin
      ctl(1'b0, 1'b0, 1'b1);
      ctl(1'b0, 1'b1, 1'b1);
    end
    chk("R11 null ignores clocks", {24'b0, statusByte}, 32'h01);
    readWord(8'h22, w); chk("R11 stored word", {16'b0, w}, 32'h0F0F);

    // R12: abandon a write after 8 data bits
    openCmd();
    sendBit(1'b1);
    sendField(16'd1, 2);
    sendField(16'h30, 8);
    sendField(16'h00AA, 8);
    closeCmd();
    readWord(8'h30, w); chk("R12 abandoned write", {16'b0, w}, 32'h8001);

    // R8: erase with zero data bits
    cmd(2'd3, 8'h30, 16'h0000, 1'b1);
    readWord(8'h30, w); chk("R8 erase", {16'b0, w}, 32'hFFFF);
    readWord(8'h31, w); chk("R8 neighbour kept", {16'b0, w}, 32'h1234);

    // R3: zero bits in idle are not a start bit
    openCmd();
    sendBit(1'b0);
    sendBit(1'b0);
    sendBit(1'b1);
    sendField(16'd1, 2);
    sendField(16'h55, 8);
    sendField(16'h3C3C, 16);
    closeCmd();
    readWord(8'h55, w); chk("R3 start bit", {16'b0, w}, 32'h3C3C);

    // R2: repeated clock-high bytes give one edge
    openCmd();
    sendBit(1'b1);
    sendField(16'd1, 2);
    sendField(16'h44, 8);
    for (int i = 15; i >= 0; i--) begin
      ctl(1'b1, 1'b0, 16'hC671 >> i);
      ctl(1'b1, 1'b1, 16'hC671 >> i);
      ctl(1'b1, 1'b1, 16'hC671 >> i);
    end
    closeCmd();
    readWord(8'h44, w); chk("R2 single edge", {16'b0, w}, 32'hC671);

    // R9: write-all
    cmd(2'd0, 8'h40, 16'h5AA5, 1'b1);
    readWord(8'h00, w); chk("R9 fill 00", {16'b0, w}, 32'h5AA5);
    readWord(8'h7F, w); chk("R9 fill 7F", {16'b0, w}, 32'h5AA5);
    readWord(8'hFF, w); chk("R9 fill FF", {16'b0, w}, 32'h5AA5);

    // R10: erase-all
    cmd(2'd0, 8'h80, 16'hFFFF, 1'b1);
    readWord(8'h00, w); chk("R10 erase-all 00", {16'b0, w}, 32'hFFFF);
    readWord(8'h80, w); chk("R10 erase-all 80", {16'b0, w}, 32'hFFFF);
    readWord(8'hC3, w); chk("R10 erase-all C3", {16'b0, w}, 32'hFFFF);

    // R6: disable, then R5 with write and write-all
    cmd(2'd0, 8'h00, 16'h0, 1'b0);
    cmd(2'd1, 8'h05, 16'h1111, 1'b1);
    readWord(8'h05, w); chk("R6 disable blocks write", {16'b0, w}, 32'hFFFF);
    cmd(2'd0, 8'h40, 16'h1357, 1'b1);
    readWord(8'h9A, w); chk("R5 disabled write-all", {16'b0, w}, 32'hFFFF);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule